// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the memory-mapped register front end of a per-core interrupt controller. It owns a 4096-byte window in which every register occupies an 8-byte slot. A request carries an offset, a byte count, a read/write flag and write data. The block maps the offset to an internal register index. A read returns the addressed bytes in the low lanes of the response. A write merges the enabled bytes into the stored 32-bit value. Reserved offsets, offsets beyond the window, illegal byte counts and accesses that cross a slot boundary are answered with a fault, and nothing is stored.

Each access runs through a four-state machine:
- `ST_IDLE` holds `req_ready` high. On `req_valid` the request is captured and the machine moves to `ST_DECODE`.
- `ST_DECODE` registers the decoded index, byte lane and fault flag, then moves unconditionally to `ST_EXEC`.
- `ST_EXEC` performs the register write, or latches the read data, and moves unconditionally to `ST_RESP`.
- `ST_RESP` drives `rsp_valid` for exactly one cycle and returns unconditionally to `ST_IDLE`.

The storage holds 21 single registers and three banked arrays of 16 slots each. These are the in-service, trigger-mode and pending-request status words. Reset loads an identity value built from the core number and a fixed revision word. Prioritisation, delivery and the timer datapath live in neighbouring blocks.

Top module: `irqc_reg_front`

## Requirements
- R1: `req_ready` is high only in `ST_IDLE`. A request accepted on a clock edge gives `rsp_valid` high for exactly one cycle, starting after the third following edge. `req_ready` and `rsp_valid` are never high together.
- R2: Single registers decode from the 8-byte-aligned offset as follows:
  - identity 0x20, revision 0x30
  - task priority 0x80, arbitration priority 0x90, processor priority 0xA0
  - interrupt acknowledge 0xB0
  - logical destination 0xD0, destination format 0xE0, spurious vector 0xF0
  - error status 0x280
  - command low 0x300, command high 0x310
  - vector entries for timer 0x320, thermal 0x330, performance counters 0x340, input pin 0 at 0x350, input pin 1 at 0x360 and error at 0x370
  - initial count 0x380, current count 0x390, divider 0x3E0
- R3: The in-service array is based at 0x100, the trigger-mode array at 0x180 and the request array at 0x200. Each array has 16 independent slots with an 8-byte stride, and the slot number is (offset − base)/8.
- R4: Any other aligned slot below 0x1000 is reserved, including the odd slots such as 0x28 and 0x3A8. Accessing a reserved slot returns `rsp_fault`=1.
- R5: An offset of 0x1000 or above faults. It does not alias into the window.
- R6: The byte lane is offset[2:0] and the byte count is `req_size`. The access faults when lane+size > 8 (the access crosses an 8-byte slot), when size is 0, or when size is greater than 4.
- R7: A faulting access changes no register and returns `rsp_rdata`=0.
- R8: After reset, identity reads `core_id` shifted left by 24, revision reads 0x00050014, and every other register reads 0.
- R9: A read returns register bytes lane..lane+size−1 in `rsp_rdata` bytes 0..size−1. The remaining response bytes are zero, and register bytes 4..7 of a slot always read as zero.
- R10: A write copies `req_wdata` byte k into register byte lane+k, for k < size and lane+k < 4. All other register bytes keep their value.
- R11: Writes to revision (0x30), processor priority (0xA0) and current count (0x390) complete without a fault and leave the stored value unchanged.
- R12: A write response carries `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_id | input | 8 | Core number, sampled into the identity register at reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 16 | Byte offset within the register window |
| req_size | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, first byte in bits 7:0 |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Access was rejected |
| rsp_rdata | output | 32 | Read data, first byte in bits 7:0 |

## Verification
The assertions watch the handshake on every cycle: they check the fixed three-edge latency, the single-cycle response pulse and the exclusion between `req_ready` and `rsp_valid`. They also check that out-of-window and slot-crossing requests come back faulted, and that faulted responses and write responses carry zero data. Only the bench scenarios can show that the decode map, the array slot arithmetic, the byte-lane extraction and merge, the reset contents, the read-only protection and the absence of side effects on faults all hold. It does this by reading stored state back through the same window and comparing against an offset-keyed model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_EXEC,
        ST_RESP
    } fe_state_t;

    localparam int unsigned SINGLE_CNT = 21;

    localparam int unsigned IDX_IDENT     = 0;
    localparam int unsigned IDX_REVISION  = 1;
    localparam int unsigned IDX_TASK_PRIO = 2;
    localparam int unsigned IDX_ARB_PRIO  = 3;
    localparam int unsigned IDX_PROC_PRIO = 4;
    localparam int unsigned IDX_ACK       = 5;
    localparam int unsigned IDX_LOG_DEST  = 6;
    localparam int unsigned IDX_DEST_FMT  = 7;
    localparam int unsigned IDX_SPUR_VEC  = 8;
    localparam int unsigned IDX_ERR_STAT  = 9;
    localparam int unsigned IDX_CMD_LO    = 10;
    localparam int unsigned IDX_CMD_HI    = 11;
    localparam int unsigned IDX_VEC_TIMER = 12;
    localparam int unsigned IDX_VEC_THERM = 13;
    localparam int unsigned IDX_VEC_PERF  = 14;
    localparam int unsigned IDX_VEC_PIN0  = 15;
    localparam int unsigned IDX_VEC_PIN1  = 16;
    localparam int unsigned IDX_VEC_ERR   = 17;
    localparam int unsigned IDX_CNT_INIT  = 18;
    localparam int unsigned IDX_CNT_NOW   = 19;
    localparam int unsigned IDX_CNT_DIV   = 20;

    localparam int unsigned BASE_INSVC = 32'h100;
    localparam int unsigned BASE_TRIG  = 32'h180;
    localparam int unsigned BASE_REQ   = 32'h200;

    localparam logic [31:0] REVISION_RESET = 32'h0005_0014;

    // Aligned window offset of each single register (R2)
    function automatic int unsigned single_offset(input int unsigned i);
        case (i)
            IDX_IDENT:     return 32'h020;
            IDX_REVISION:  return 32'h030;
            IDX_TASK_PRIO: return 32'h080;
            IDX_ARB_PRIO:  return 32'h090;
            IDX_PROC_PRIO: return 32'h0A0;
            IDX_ACK:       return 32'h0B0;
            IDX_LOG_DEST:  return 32'h0D0;
            IDX_DEST_FMT:  return 32'h0E0;
            IDX_SPUR_VEC:  return 32'h0F0;
            IDX_ERR_STAT:  return 32'h280;
            IDX_CMD_LO:    return 32'h300;
            IDX_CMD_HI:    return 32'h310;
            IDX_VEC_TIMER: return 32'h320;
            IDX_VEC_THERM: return 32'h330;
            IDX_VEC_PERF:  return 32'h340;
            IDX_VEC_PIN0:  return 32'h350;
            IDX_VEC_PIN1:  return 32'h360;
            IDX_VEC_ERR:   return 32'h370;
            IDX_CNT_INIT:  return 32'h380;
            IDX_CNT_NOW:   return 32'h390;
            IDX_CNT_DIV:   return 32'h3E0;
            default:       return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Registers that ignore bus writes (R11)
    function automatic logic is_read_only(input int unsigned i);
        return (i == IDX_REVISION) || (i == IDX_PROC_PRIO) || (i == IDX_CNT_NOW);
    endfunction

endpackage

// File: rtl/irqc_offset_decode.sv
module irqc_offset_decode
    import irqc_pkg::*;
#(
    parameter int unsigned OFS_W     = 16,
    parameter int unsigned SIZE_W    = 3,
    parameter int unsigned IDX_W     = 7,
    parameter int unsigned SLOTS     = 16,
    parameter int unsigned BUS_BYTES = 4
) (
    input  logic [OFS_W-1:0]  offset,
    input  logic [SIZE_W-1:0] size,
    output logic [IDX_W-1:0]  idx,
    output logic [2:0]        lane,
    output logic              fault
);

    localparam int unsigned WINDOW = 4096;
    localparam int unsigned STRIDE = 8;
    localparam int unsigned SPAN   = SLOTS * STRIDE;

    int unsigned aligned;
    int unsigned end_byte;
    logic        in_window;
    logic        hit;
    logic        straddle;
    logic        bad_size;

    always_comb begin
        aligned   = 32'(offset) & 32'hFFFF_FFF8;
        in_window = 32'(offset) < WINDOW;
        hit       = 1'b0;
        idx       = '0;

        for (int unsigned i = 0; i < SINGLE_CNT; i++) begin
            if (aligned == single_offset(i)) begin
                idx = IDX_W'(i);
                hit = 1'b1;
            end
        end

        if (aligned >= BASE_INSVC && aligned < BASE_INSVC + SPAN) begin
            idx = IDX_W'(SINGLE_CNT + (aligned - BASE_INSVC) / STRIDE);
            hit = 1'b1;
        end
        if (aligned >= BASE_TRIG && aligned < BASE_TRIG + SPAN) begin
            idx = IDX_W'(SINGLE_CNT + SLOTS + (aligned - BASE_TRIG) / STRIDE);
            hit = 1'b1;
        end
        if (aligned >= BASE_REQ && aligned < BASE_REQ + SPAN) begin
            idx = IDX_W'(SINGLE_CNT + 2 * SLOTS + (aligned - BASE_REQ) / STRIDE);
            hit = 1'b1;
        end

        lane     = offset[2:0];
        end_byte = 32'(lane) + 32'(size);
        straddle = end_byte > STRIDE;
        bad_size = (size == '0) || (32'(size) > BUS_BYTES);
        fault    = !in_window || !hit || straddle || bad_size;
    end

endmodule

// File: rtl/irqc_byte_lanes.sv
module irqc_byte_lanes #(
    parameter int unsigned DW     = 32,
    parameter int unsigned SIZE_W = 3
) (
    input  logic [2:0]        lane,
    input  logic [SIZE_W-1:0] size,
    input  logic [DW-1:0]     stored,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     merged
);

    localparam int unsigned NB = DW / 8;

    logic [2*DW-1:0] wide;

    // Read path: shift the addressed byte down to lane 0, keep size bytes
    always_comb begin
        wide = {{DW{1'b0}}, stored} >> ({3'b000, lane} << 3);
        for (int unsigned b = 0; b < NB; b++) begin
            rdata[8*b +: 8] = (b < 32'(size)) ? wide[8*b +: 8] : 8'h00;
        end
    end

    // Write path: place wdata byte k on register byte lane+k
    always_comb begin
        int unsigned rel;
        merged = stored;
        for (int unsigned b = 0; b < NB; b++) begin
            rel = b - 32'(lane);
            if (b >= 32'(lane) && rel < 32'(size) && rel < NB) begin
                merged[8*b +: 8] = wdata[8*rel +: 8];
            end
        end
    end

endmodule

// File: rtl/irqc_reg_bank.sv
module irqc_reg_bank
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_REGS = 69,
    parameter int unsigned IDX_W    = 7,
    parameter int unsigned DW       = 32,
    parameter int unsigned CORE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] core_id,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DW-1:0]     wvalue,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DW-1:0]     rvalue
);

    localparam int unsigned ID_SHIFT = DW - CORE_W;

    logic [NUM_REGS-1:0][DW-1:0] flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == IDX_IDENT) begin : g_ident
            logic [DW-1:0] r;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r <= DW'(core_id) << ID_SHIFT;
                end else if (we && widx == IDX_W'(g)) begin
                    r <= wvalue;
                end
            end
            assign flat[g] = r;
        end else if (is_read_only(g)) begin : g_fixed
            localparam logic [DW-1:0] FIXED =
                (g == IDX_REVISION) ? DW'(REVISION_RESET) : '0;
            assign flat[g] = FIXED;
        end else begin : g_rw
            logic [DW-1:0] r;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r <= '0;
                end else if (we && widx == IDX_W'(g)) begin
                    r <= wvalue;
                end
            end
            assign flat[g] = r;
        end
    end

    assign rvalue = (32'(ridx) < NUM_REGS) ? flat[ridx] : '0;

endmodule

// File: rtl/irqc_reg_front.sv
module irqc_reg_front
    import irqc_pkg::*;
#(
    parameter int unsigned OFS_W  = 16,
    parameter int unsigned SIZE_W = 3,
    parameter int unsigned DW     = 32,
    parameter int unsigned CORE_W = 8,
    parameter int unsigned SLOTS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] core_id,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DW-1:0]     rsp_rdata
);

    localparam int unsigned NUM_REGS  = SINGLE_CNT + 3 * SLOTS;
    localparam int unsigned IDX_W     = $clog2(NUM_REGS);
    localparam int unsigned BUS_BYTES = DW / 8;

    fe_state_t state, state_nx;

    logic              q_write;
    logic [OFS_W-1:0]  q_offset;
    logic [SIZE_W-1:0] q_size;
    logic [DW-1:0]     q_wdata;

    logic [IDX_W-1:0]  dec_idx, d_idx;
    logic [2:0]        dec_lane, d_lane;
    logic              dec_fault, d_fault;

    logic [DW-1:0]     bank_rvalue;
    logic [DW-1:0]     lane_rdata;
    logic [DW-1:0]     lane_merged;
    logic              bank_we;

    logic              rsp_fault_q;
    logic [DW-1:0]     rsp_rdata_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_DECODE;
            ST_DECODE: state_nx = ST_EXEC;
            ST_EXEC:   state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Request capture, decode staging and response staging
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write     <= 1'b0;
            q_offset    <= '0;
            q_size      <= '0;
            q_wdata     <= '0;
            d_idx       <= '0;
            d_lane      <= '0;
            d_fault     <= 1'b0;
            rsp_fault_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_write  <= req_write;
                        q_offset <= req_offset;
                        q_size   <= req_size;
                        q_wdata  <= req_wdata;
                    end
                end
                ST_DECODE: begin
                    d_idx   <= dec_idx;
                    d_lane  <= dec_lane;
                    d_fault <= dec_fault;
                end
                ST_EXEC: begin
                    rsp_fault_q <= d_fault;
                    rsp_rdata_q <= (!d_fault && !q_write) ? lane_rdata : '0;
                end
                ST_RESP: begin
                    rsp_fault_q <= 1'b0;
                    rsp_rdata_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_fault = rsp_valid && rsp_fault_q;
        rsp_rdata = rsp_valid ? rsp_rdata_q : '0;
        bank_we   = (state == ST_EXEC) && q_write && !d_fault;
    end

    irqc_offset_decode #(
        .OFS_W     (OFS_W),
        .SIZE_W    (SIZE_W),
        .IDX_W     (IDX_W),
        .SLOTS     (SLOTS),
        .BUS_BYTES (BUS_BYTES)
    ) u_decode (
        .offset (q_offset),
        .size   (q_size),
        .idx    (dec_idx),
        .lane   (dec_lane),
        .fault  (dec_fault)
    );

    irqc_byte_lanes #(
        .DW     (DW),
        .SIZE_W (SIZE_W)
    ) u_lanes (
        .lane   (d_lane),
        .size   (q_size),
        .stored (bank_rvalue),
        .wdata  (q_wdata),
        .rdata  (lane_rdata),
        .merged (lane_merged)
    );

    irqc_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .DW       (DW),
        .CORE_W   (CORE_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_id (core_id),
        .we      (bank_we),
        .widx    (d_idx),
        .wvalue  (lane_merged),
        .ridx    (d_idx),
        .rvalue  (bank_rvalue)
    );

endmodule

// File: rtl/irqc_reg_front_chk.sv
module irqc_reg_front_chk #(
    parameter int unsigned OFS_W  = 16,
    parameter int unsigned SIZE_W = 3,
    parameter int unsigned DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [OFS_W-1:0]  req_offset,
    input logic [SIZE_W-1:0] req_size,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [DW-1:0]     rsp_rdata
);

    logic accept;
    assign accept = req_valid && req_ready;

    assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##2 rsp_valid);

    assert_window_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && 32'(req_offset) >= 32'd4096) |=> ##2 rsp_fault);

    assert_straddle_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ({1'b0, req_offset[2:0]} + 4'(req_size)) > 4'd8) |=> ##2 rsp_fault);

    assert_fault_nodata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_rdata == '0));

    assert_write_nodata_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |=> ##2 (rsp_rdata == '0));

endmodule

bind irqc_reg_front irqc_reg_front_chk #(
    .OFS_W  (OFS_W),
    .SIZE_W (SIZE_W),
    .DW     (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_offset (req_offset),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/irqc_reg_front_test.sv
`timescale 1ns/1ps
module irqc_reg_front_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  core_id;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [15:0] req_offset;
    logic [2:0]  req_size;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_rdata;

    always #10 clk = ~clk;

    irqc_reg_front uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_id    (core_id),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_offset (req_offset),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_rdata  (rsp_rdata)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] mdl [512];

    // Offset legality from R2..R5
    function automatic bit legal_slot(int off);
        int a;
        if (off >= 4096) return 0;
        a = off & ~7;
        case (a)
            'h020, 'h030, 'h080, 'h090, 'h0A0, 'h0B0, 'h0D0, 'h0E0, 'h0F0,
            'h280, 'h300, 'h310, 'h320, 'h330, 'h340, 'h350, 'h360, 'h370,
            'h380, 'h390, 'h3E0: return 1;
            default: return (a >= 'h100 && a < 'h280);
        endcase
    endfunction

    // R11 read-only slots
    function automatic bit ro_slot(int off);
        int a;
        a = off & ~7;
        return (a == 'h030) || (a == 'h0A0) || (a == 'h390);
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(bit wr, int off, int sz, logic [31:0] wd, string tag);
        bit          efault;
        logic [31:0] erd;
        logic [63:0] wide;
        logic [31:0] v;
        int          lane;
        int          cnt;
        lane   = off & 7;
        efault = !legal_slot(off) || sz == 0 || sz > 4 || (lane + sz > 8);
        erd    = '0;
        if (!efault && !wr) begin
            wide = {32'h0, mdl[(off & 'hFF8) >> 3]} >> (8 * lane);
            for (int k = 0; k < 4; k++) if (k < sz) erd[8*k +: 8] = wide[8*k +: 8];
        end
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "ready before request", {31'b0, req_ready}, 32'h1);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = 16'(off);
        req_size   = 3'(sz);
        req_wdata  = wd;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 1;
        while (rsp_valid !== 1'b1 && cnt < 8) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 3, "R1", "response latency", 32'(cnt), 32'd3);
        chk(rsp_fault === efault, tag, "fault flag", {31'b0, rsp_fault}, {31'b0, efault});
        chk(rsp_rdata === erd, tag, "read data", rsp_rdata, erd);
        if (wr && !efault && !ro_slot(off)) begin
            v = mdl[(off & 'hFF8) >> 3];
            for (int k = 0; k < sz; k++) if (lane + k < 4) v[8*(lane+k) +: 8] = wd[8*k +: 8];
            mdl[(off & 'hFF8) >> 3] = v;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int a;
        int tries;
        void'($urandom(32'd7321));
        for (int i = 0; i < 512; i++) mdl[i] = '0;
        mdl['h20 >> 3] = 32'h5A00_0000;
        mdl['h30 >> 3] = 32'h0005_0014;
        rst_n = 1'b0; core_id = 8'h5A; req_valid = 1'b0; req_write = 1'b0;
        req_offset = '0; req_size = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R1", "no response in reset", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;

        // R8 reset contents
        access(0, 'h20, 4, 0, "R8");
        access(0, 'h30, 4, 0, "R8");
        access(0, 'h80, 4, 0, "R8");
        access(0, 'h1F8, 4, 0, "R8");
        // R2 single registers write/read
        access(1, 'h80, 4, 32'h1111_2222, "R2");
        access(1, 'h3E0, 4, 32'h0000_000B, "R2");
        access(1, 'h370, 4, 32'hCAFE_0001, "R2");
        access(0, 'h80, 4, 0, "R2");
        access(0, 'h3E0, 4, 0, "R2");
        access(0, 'h370, 4, 0, "R2");
        // R3 array slots are independent
        access(1, 'h100, 4, 32'hA0A0_0000, "R3");
        access(1, 'h178, 4, 32'hA0A0_000F, "R3");
        access(1, 'h1F8, 4, 32'hB0B0_000F, "R3");
        access(1, 'h200, 4, 32'hC0C0_0000, "R3");
        access(1, 'h278, 4, 32'hC0C0_000F, "R3");
        access(0, 'h100, 4, 0, "R3");
        access(0, 'h108, 4, 0, "R3");
        access(0, 'h178, 4, 0, "R3");
        access(0, 'h1F8, 4, 0, "R3");
        access(0, 'h278, 4, 0, "R3");
        // R4 reserved slots
        access(0, 'h28, 4, 0, "R4");
        access(1, 'h40, 4, 32'hFFFF_FFFF, "R4");
        access(0, 'h3A8, 4, 0, "R4");
        access(0, 'hFF8, 4, 0, "R4");
        // R5 beyond window, no aliasing into identity
        access(1, 'h1020, 4, 32'hDEAD_BEEF, "R5");
        access(0, 'h1000, 4, 0, "R5");
        access(0, 'h20, 4, 0, "R7");
        // R6 crossing and size rules, R7 no side effect
        access(1, 'h85, 4, 32'h9999_9999, "R6");
        access(1, 'h8E, 4, 32'h9999_9999, "R6");
        access(0, 'h80, 0, 0, "R6");
        access(0, 'h80, 5, 0, "R6");
        access(0, 'h84, 4, 0, "R6");
        access(0, 'h80, 4, 0, "R7");
        // R9 lanes
        access(0, 'h81, 2, 0, "R9");
        access(0, 'h83, 1, 0, "R9");
        access(0, 'h86, 2, 0, "R9");
        // R10 merge
        access(1, 'h82, 1, 32'h0000_0077, "R10");
        access(1, 'h370, 2, 32'h0000_5A5A, "R10");
        access(1, 'h83, 3, 32'h00EE_DDCC, "R10");
        access(0, 'h80, 4, 0, "R10");
        access(0, 'h370, 4, 0, "R10");
        // R11 read-only
        access(1, 'h30, 4, 32'h1234_5678, "R11");
        access(1, 'hA0, 4, 32'h1234_5678, "R11");
        access(1, 'h390, 4, 32'h1234_5678, "R11");
        access(0, 'h30, 4, 0, "R11");
        access(0, 'hA0, 4, 0, "R11");
        access(0, 'h390, 4, 0, "R11");
        // R12 write response
        access(1, 'hD0, 4, 32'h0F0F_0F0F, "R12");

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            int pick;
            int sz;
            pick = int'($urandom % 10);
            if (pick < 8) begin
                tries = 0;
                a = int'($urandom % 128) * 8;
                while (!legal_slot(a) && tries < 64) begin
                    a = int'($urandom % 128) * 8;
                    tries++;
                end
                a = a + int'($urandom % 8);
            end else begin
                a = int'($urandom % 65536);
            end
            sz = (pick == 9) ? int'($urandom % 8) : 1 + int'($urandom % 4);
            access(bit'($urandom % 2), a, sz, $urandom, "R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule